// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block holds the digital state behind four digitally controlled potentiometers. Each pot has one 8-bit wiper code, which picks one of 256 tap positions, and four 8-bit stored settings. The stored settings stand in for nonvolatile memory: the reset input does not clear them. A host issues one-cycle command strobes. A command can write a stored setting, copy a stored setting into the wiper, save the live wiper into a stored setting, or move the wiper up or down by one tap.

After reset is released, the bank restores the wipers one pot per cycle, from pot 0 to pot 3. Each wiper is loaded from that pot's setting slot 0. When the last pot is loaded, the bank raises `ready`. A real nonvolatile write is slow. Any command that changes a stored setting therefore starts a busy window that lasts a set number of cycles. A setting write that arrives during that window is discarded and raises a sticky error flag. Commands that only touch the wiper still run during the window.

Top module: `quad_wiper_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ready`, `busy` and `drop_err` are all 0 after that edge.
- R2: After reset is released, pot k's wiper is loaded from its slot 0 at the (k+1)-th rising edge. `ready` rises at the 4th edge and then stays high until the next reset.
- R3: A command presented while `ready` is low has no effect: no wiper change, no setting change, no busy window and no error.
- R4: The op field `cmd_op`=1 copies slot `cmd_reg` of pot `cmd_pot` into that pot's wiper. The new wiper value is visible after the accepting edge.
- R5: The op field `cmd_op`=3 moves the wiper of pot `cmd_pot` one tap: up when `cmd_up`=1 and down when `cmd_up`=0. A step up at 255 and a step down at 0 leave the wiper unchanged.
- R6: The op field `cmd_op`=0 stores `cmd_data` into slot `cmd_reg` of pot `cmd_pot`. The op field `cmd_op`=2 stores that pot's current wiper there. Either command, when accepted with `busy` low, holds `busy` high for exactly BUSY_CYCLES cycles, starting at the accepting edge.
- R7: A setting write (op 0 or 2) accepted while `busy` is high is discarded. It sets `drop_err`, which stays high until reset.
- R8: The stored settings keep their contents through a reset. The recall after reset uses the values written before it.
- R9: Op 1 and op 3 commands run normally while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | 0 write setting, 1 setting to wiper, 2 wiper to setting, 3 step |
| cmd_pot | input | 2 | Target pot |
| cmd_reg | input | 2 | Target setting slot |
| cmd_up | input | 1 | Step direction, 1 up, 0 down |
| cmd_data | input | 8 | Data for op 0 |
| wiper_codes | output | 32 | Wiper codes, pot k in bits [8k+7:8k] |
| ready | output | 1 | Recall after reset has finished |
| busy | output | 1 | Nonvolatile write window active |
| drop_err | output | 1 | Sticky flag for a discarded setting write |

## Verification
Every result in this block is registered once. A wiper load, a step, the start of `busy` and the setting of `drop_err` all appear after the edge that accepts the command. `busy` then falls exactly BUSY_CYCLES edges later. The recall puts pot k's value on the output after edge k+1 following the release of reset. The bench changes inputs 1 ns after a falling edge and updates its behavioural model on each rising edge. It compares every output at the next falling edge, so each comparison sees exactly one edge of effect. Wipers whose source setting was never written are left out of the comparison.

// File: rtl/qwb_pkg.sv
// Shared command encoding for the quad wiper bank.
package qwb_pkg;
    typedef enum logic [1:0] {
        OP_SET_WRITE  = 2'd0,
        OP_SET_TO_WIP = 2'd1,
        OP_WIP_TO_SET = 2'd2,
        OP_STEP       = 2'd3
    } qwb_op_e;
endpackage

// File: rtl/qwb_recall_seq.sv
// Power-up recall sequencer.
// What it does: after reset it walks an index from 0 to NUM_POTS-1, one step
// per cycle, and raises ready once the last index has been served.
// Assumes: NUM_POTS >= 1 and IW is wide enough to hold NUM_POTS-1.
module qwb_recall_seq #(
    parameter int NUM_POTS = 4,
    parameter int IW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          load_en,
    output logic [IW-1:0] load_idx,
    output logic          ready
);
    localparam logic [IW-1:0] LAST = IW'(NUM_POTS - 1);

    // Advance the index each cycle until the last pot is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_idx <= '0;
            ready    <= 1'b0;
        end else if (!ready) begin
            if (load_idx == LAST) ready <= 1'b1;
            else                  load_idx <= load_idx + 1'b1;
        end
    end

    // A load happens on every cycle before ready.
    assign load_en = !ready;
endmodule

// File: rtl/qwb_nv_timer.sv
// Busy-window timer that models the slow nonvolatile write.
// What it does: a start pulse holds busy high for exactly CYCLES cycles.
// Assumes: the caller never pulses start while busy is high.
module qwb_nv_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/qwb_wiper_cell.sv
// One volatile wiper register.
// What it does: a parallel load, or a one-tap step that saturates at both ends.
// Assumes: load takes priority over step. The register has no reset, so its
// value is undefined until the recall loads it.
module qwb_wiper_cell #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step_en,
    input  logic             step_up,
    output logic [WIDTH-1:0] wiper
);
    localparam logic [WIDTH-1:0] TOP = '1;

    // Parallel load, or a saturating step of one tap.
    always_ff @(posedge clk) begin
        if (load_en) begin
            wiper <= load_val;
        end else if (step_en) begin
            if (step_up && wiper != TOP)        wiper <= wiper + 1'b1;
            else if (!step_up && wiper != '0)   wiper <= wiper - 1'b1;
        end
    end
endmodule

// File: rtl/quad_wiper_bank.sv
// Quad wiper register bank, the top level.
// What it does: stores NUM_REGS settings per pot, which survive rst_n. It
// decodes the one-cycle commands, runs the recall after reset and drives the
// busy window and the drop flag.
// Assumes: NUM_POTS and NUM_REGS are powers of two, and commands are ignored
// until ready is high.
module quad_wiper_bank #(
    parameter int NUM_POTS    = 4,
    parameter int NUM_REGS    = 4,
    parameter int WIDTH       = 8,
    parameter int BUSY_CYCLES = 200,
    localparam int PW = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
    localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic [PW-1:0]             cmd_pot,
    input  logic [RW-1:0]             cmd_reg,
    input  logic                      cmd_up,
    input  logic [WIDTH-1:0]          cmd_data,
    output logic [NUM_POTS*WIDTH-1:0] wiper_codes,
    output logic                      ready,
    output logic                      busy,
    output logic                      drop_err
);
    import qwb_pkg::*;

    logic             rec_load;
    logic [PW-1:0]    rec_idx;
    logic             accept;
    logic             set_req;
    logic             set_we;
    logic [WIDTH-1:0] set_wdata;
    logic [WIDTH-1:0] wip_q [NUM_POTS];
    logic [WIDTH-1:0] set_q [NUM_POTS][NUM_REGS];

    qwb_recall_seq #(.NUM_POTS(NUM_POTS), .IW(PW)) u_recall (
        .clk(clk), .rst_n(rst_n),
        .load_en(rec_load), .load_idx(rec_idx), .ready(ready)
    );

    // Command decode: accept only after recall; setting writes are gated by busy.
    always_comb begin
        accept    = cmd_valid && ready;
        set_req   = accept && (cmd_op == OP_SET_WRITE || cmd_op == OP_WIP_TO_SET);
        set_we    = set_req && !busy;
        set_wdata = (cmd_op == OP_SET_WRITE) ? cmd_data : wip_q[cmd_pot];
    end

    qwb_nv_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(set_we), .busy(busy)
    );

    // Sticky record of a setting write dropped during the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)        drop_err <= 1'b0;
        else if (set_req && busy) drop_err <= 1'b1;
    end

    generate
        for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
            logic             ld_en;
            logic [WIDTH-1:0] ld_val;
            logic             st_en;

            // Load from slot 0 during recall, else from the slot the command selects.
            always_comb begin
                ld_en  = (rec_load && rec_idx == PW'(p)) ||
                         (accept && cmd_op == OP_SET_TO_WIP && cmd_pot == PW'(p));
                ld_val = rec_load ? set_q[p][0] : set_q[p][cmd_reg];
                st_en  = accept && cmd_op == OP_STEP && cmd_pot == PW'(p);
            end

            qwb_wiper_cell #(.WIDTH(WIDTH)) u_cell (
                .clk(clk), .load_en(ld_en), .load_val(ld_val),
                .step_en(st_en), .step_up(cmd_up), .wiper(wip_q[p])
            );

            assign wiper_codes[p*WIDTH +: WIDTH] = wip_q[p];

            for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
                // Setting slot, not reset, so it models nonvolatile storage.
                always_ff @(posedge clk) begin
                    if (set_we && cmd_pot == PW'(p) && cmd_reg == RW'(r))
                        set_q[p][r] <= set_wdata;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/qwb_checker.sv
// Assertion checker for quad_wiper_bank, attached to the top module by bind.
// Assumes: the same parameters as the bank it is bound to.
module qwb_checker #(
    parameter int NUM_POTS = 4,
    parameter int WIDTH    = 8,
    parameter int PW       = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic [1:0]                cmd_op,
    input logic [PW-1:0]             cmd_pot,
    input logic                      cmd_up,
    input logic [NUM_POTS*WIDTH-1:0] wiper_codes,
    input logic                      ready,
    input logic                      busy,
    input logic                      drop_err
);
    logic [WIDTH-1:0] cur;
    logic             wr_cmd;
    assign cur    = wiper_codes[int'(cmd_pot)*WIDTH +: WIDTH];
    assign wr_cmd = cmd_valid && ready && (cmd_op == 2'd0 || cmd_op == 2'd2);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!ready && !busy && !drop_err));

    a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r3_no_busy_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !busy) |=> !busy);

    a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && cmd_op == 2'd3 && cmd_up && cur == '1) |=> $stable(wiper_codes));

    a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && cmd_op == 2'd3 && !cmd_up && cur == '0) |=> $stable(wiper_codes));

    a_r6_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy) |=> busy);

    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy) |=> drop_err);

    a_r7_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> drop_err);
endmodule

bind quad_wiper_bank qwb_checker #(.NUM_POTS(NUM_POTS), .WIDTH(WIDTH), .PW(PW)) u_qwb_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_up(cmd_up), .wiper_codes(wiper_codes),
    .ready(ready), .busy(busy), .drop_err(drop_err)
);

// File: tb/quad_wiper_bank_bench.sv
`timescale 1ns/100ps
// Bench: a behavioural reference model, compared with the design on every falling edge.
module quad_wiper_bank_bench;
    localparam int BUSY = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_pot = 2'd0;
    logic [1:0]  cmd_reg = 2'd0;
    logic        cmd_up = 1'b0;
    logic [7:0]  cmd_data = 8'd0;
    logic [31:0] wiper_codes;
    logic        ready, busy, drop_err;

    quad_wiper_bank #(.BUSY_CYCLES(BUSY)) u_quad_wiper_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_up(cmd_up), .cmd_data(cmd_data),
        .wiper_codes(wiper_codes), .ready(ready), .busy(busy), .drop_err(drop_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state.
    int m_w[4];
    bit m_wk[4];
    int m_set[4][4];
    bit m_sk[4][4];
    int m_cnt = 0;
    bit m_ready = 0;
    int m_idx = 0;
    bit m_err = 0;
    bit started = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int wip(input int p);
        return int'(wiper_codes[p*8 +: 8]);
    endfunction

    // Model update on each rising edge, from the inputs held across that edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ready = 0; m_idx = 0; m_cnt = 0; m_err = 0;
        end else if (!m_ready) begin
            m_w[m_idx] = m_set[m_idx][0];
            m_wk[m_idx] = m_sk[m_idx][0];
            if (m_idx == 3) m_ready = 1; else m_idx++;
        end else begin
            bit was_busy;
            bit go;
            was_busy = (m_cnt > 0);
            go = 0;
            if (m_cnt > 0) m_cnt--;
            if (cmd_valid) begin
                case (cmd_op)
                    2'd0, 2'd2: begin
                        if (was_busy) m_err = 1;
                        else begin
                            go = 1;
                            if (cmd_op == 2'd0) begin
                                m_set[cmd_pot][cmd_reg] = cmd_data;
                                m_sk[cmd_pot][cmd_reg] = 1;
                            end else begin
                                m_set[cmd_pot][cmd_reg] = m_w[cmd_pot];
                                m_sk[cmd_pot][cmd_reg] = m_wk[cmd_pot];
                            end
                        end
                    end
                    2'd1: begin
                        m_w[cmd_pot] = m_set[cmd_pot][cmd_reg];
                        m_wk[cmd_pot] = m_sk[cmd_pot][cmd_reg];
                    end
                    default: begin
                        if (cmd_up && m_w[cmd_pot] < 255) m_w[cmd_pot]++;
                        else if (!cmd_up && m_w[cmd_pot] > 0) m_w[cmd_pot]--;
                    end
                endcase
            end
            if (go) m_cnt = BUSY;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R2/R3 ready", int'(ready), int'(m_ready));
            chk("R6 busy", int'(busy), int'(m_cnt > 0));
            chk("R7 drop_err", int'(drop_err), int'(m_err));
            for (int p = 0; p < 4; p++)
                if (m_wk[p]) chk("R4/R5 wiper", wip(p), m_w[p]);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cmd(input int op, input int pot, input int rg, input bit up, input int data);
        @(negedge clk); #1;
        cmd_valid = 1; cmd_op = 2'(op); cmd_pot = 2'(pot); cmd_reg = 2'(rg);
        cmd_up = up; cmd_data = 8'(data);
        @(negedge clk); #1;
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        while (busy) begin @(negedge clk); #1; end
    endtask

    function automatic int seed_val(input int p, input int r);
        if (p == 2 && r == 3) return 255;
        if (p == 3 && r == 3) return 0;
        return (p * 40 + r * 9 + 5) % 256;
    endfunction

    task automatic do_reset(input bit cmd_during_recall);
        @(negedge clk); #1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(ready), 0);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 drop_err in reset", int'(drop_err), 0);
        #1;
        rst_n = 1;
        if (cmd_during_recall) begin
            cmd_valid = 1; cmd_op = 2'd0; cmd_pot = 2'd0; cmd_reg = 2'd1; cmd_data = 8'h55;
        end
        repeat (3) @(negedge clk);
        chk("R2 not ready after 3 edges", int'(ready), 0);
        @(negedge clk);
        chk("R2 ready after 4 edges", int'(ready), 1);
        chk("R3 no busy from early command", int'(busy), 0);
        #1;
        cmd_valid = 0;
    endtask

    initial begin
        int n;
        do_reset(1'b1);
        // Fill all settings (R6), then exercise a dropped write (R7).
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) begin
                cmd(0, p, r, 0, seed_val(p, r));
                wait_idle();
            end
        cmd(0, 1, 1, 0, 8'hAA);
        n = 0;
        while (busy) begin n++; @(negedge clk); #1; end
        chk("R6 busy window length", n, BUSY);
        cmd(0, 1, 1, 0, 8'h11);
        cmd(0, 1, 1, 0, 8'h22);
        chk("R7 drop_err set", int'(drop_err), 1);
        wait_idle();
        cmd(1, 1, 1, 0, 0);
        chk("R7 dropped write left slot", wip(1), 8'h11);

        // Settings survive reset, and the recall uses slot 0 (R8, R2).
        do_reset(1'b0);
        chk("R7 drop_err cleared by reset", int'(drop_err), 0);
        for (int p = 0; p < 4; p++) chk("R8 recall slot 0", wip(p), seed_val(p, 0));

        // Copy setting to wiper (R4).
        cmd(1, 1, 2, 0, 0);
        chk("R4 copy to wiper", wip(1), seed_val(1, 2));

        // Saturation at the top and bottom (R5).
        cmd(1, 2, 3, 0, 0);
        cmd(3, 2, 0, 1, 0);
        chk("R5 step up at 255", wip(2), 255);
        cmd(3, 2, 0, 0, 0);
        chk("R5 step down from 255", wip(2), 254);
        cmd(1, 3, 3, 0, 0);
        cmd(3, 3, 0, 0, 0);
        chk("R5 step down at 0", wip(3), 0);
        cmd(3, 3, 0, 1, 0);
        cmd(3, 3, 0, 1, 0);
        chk("R5 step up from 0", wip(3), 2);

        // Save the wiper to a setting, and run wiper-only commands while busy (R6, R9).
        cmd(2, 3, 1, 0, 0);
        chk("R6 busy after save", int'(busy), 1);
        cmd(1, 0, 2, 0, 0);
        chk("R9 copy while busy", wip(0), seed_val(0, 2));
        cmd(3, 1, 0, 1, 0);
        chk("R9 step while busy", wip(1), seed_val(1, 2) + 1);
        wait_idle();
        cmd(1, 3, 0, 0, 0);
        cmd(1, 3, 1, 0, 0);
        chk("R6 saved wiper recalled", wip(3), 2);
        chk("R7 no drop seen", int'(drop_err), 0);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule